// File: doc/BRIEF.md
# Masked Interrupt Merger with Lowest-Index Priority

This block gathers a set of level-sensitive interrupt requests and presents them to a CPU as one interrupt line. Each source has an enable bit. Software never writes the enable mask directly. It writes a word to a set strobe to turn chosen sources on, or to a clear strobe to turn chosen sources off. Because of this, two agents can change different sources without a read-modify-write race.

Software reads the enabled-and-pending vector through a small read port, and can read back the current mask through the same port. A combinational priority search reports the lowest-numbered enabled-pending source and a flag that says whether any such source exists. A registered OR of the enabled-pending vector drives the CPU interrupt line.

Top module: `irq_merge`

## Requirements
- R1: When `set_we` is high at a clock edge, each mask bit whose `set_data` bit is 1 becomes 1. Every other mask bit keeps its value.
- R2: When `clr_we` is high at a clock edge, each mask bit whose `clr_data` bit is 1 becomes 0. Every other mask bit keeps its value.
- R3: If a set write and a clear write name the same bit at the same edge, that bit ends at 0.
- R4: While `rst_n` is low, the mask is all zeros and `cpu_irq` is low. Every source is disabled after reset.
- R5: With `rd_sel` = 2, `rd_data` equals `req & mask`. This is the status vector, and it is combinational in both `req` and the mask.
- R6: If the status vector is nonzero, `win_valid` is 1 and `win_idx` is the position of its lowest set bit.
- R7: If the status vector is zero, `win_valid` is 0. `win_idx` carries no meaning in that case.
- R8: `cpu_irq` is the OR of the status vector as it stood at the previous clock edge. It changes exactly one cycle after the status changes.
- R9: `rd_sel` = 0 (set port) and `rd_sel` = 1 (clear port) both read as all zeros. `rd_sel` = 3 returns the current mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_we | input | 1 | Strobe for the enable-set port |
| set_data | input | NSRC | Bits to enable |
| clr_we | input | 1 | Strobe for the enable-clear port |
| clr_data | input | NSRC | Bits to disable |
| req | input | NSRC | Level interrupt requests |
| rd_sel | input | 2 | Read select: 0 set port, 1 clear port, 2 status, 3 mask |
| rd_data | output | NSRC | Read data for `rd_sel` |
| win_idx | output | IDXW | Index of the lowest enabled-pending source |
| win_valid | output | 1 | An enabled-pending source exists |
| cpu_irq | output | 1 | Registered merged interrupt to the CPU |

## Verification
The bench builds the block with its default NSRC of 32, which gives IDXW of 5. At this size all five halving stages of the priority search are in use, and both extremes of the index range can be reached: source 0 and source 31 are tested as winners. The full width also allows all-ones clear and set words, which sweep every mask bit in one write. Collisions between the set and clear strobes are tested on a single shared bit.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;

  // Read-port selector; the code values are part of the register interface.
  typedef enum logic [1:0] {
    RSEL_SETPORT = 2'd0,
    RSEL_CLRPORT = 2'd1,
    RSEL_STATUS  = 2'd2,
    RSEL_MASK    = 2'd3
  } rsel_e;

endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_we,
  input  logic [NSRC-1:0] set_data,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_data,
  output logic [NSRC-1:0] mask_o
);

  // Clear is applied after set, so a clear wins on a shared bit.
  function automatic logic [NSRC-1:0] next_mask(
    input logic [NSRC-1:0] cur,
    input logic [NSRC-1:0] on_bits,
    input logic [NSRC-1:0] off_bits
  );
    return (cur | on_bits) & ~off_bits;
  endfunction

  logic [NSRC-1:0] set_hit;
  logic [NSRC-1:0] clr_hit;
  logic [NSRC-1:0] touched;
  logic [NSRC-1:0] mask_q;

  assign set_hit = set_we ? set_data : '0;
  assign clr_hit = clr_we ? clr_data : '0;
  assign touched = set_hit | clr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= next_mask(mask_q, set_hit, clr_hit);
  end

  assign mask_o = mask_q;

  // R2 / R3: every bit named by a clear write is 0 afterwards
  assert_clear_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((mask_q & $past(clr_data)) == '0));

  // R1: set bits not also cleared are 1 afterwards
  assert_set_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((mask_q & ($past(set_data) & ~$past(clr_hit))) ==
                ($past(set_data) & ~$past(clr_hit))));

  // R1 / R2: bits named by neither write keep their value
  assert_untouched_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we || clr_we) |=> ((mask_q & ~$past(touched)) ==
                            ($past(mask_q) & ~$past(touched))));

endmodule

// File: rtl/irq_prio_find.sv
module irq_prio_find #(
  parameter int NSRC   = 32,
  localparam int LEVELS = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]   vec_i,
  output logic [LEVELS-1:0] idx_o,
  output logic              valid_o
);

  // Each stage keeps the lower half if it has any bit set, otherwise the
  // upper half; the choice is one index bit, most significant first.
  for (genvar s = 0; s < LEVELS; s++) begin : g_stage
    localparam int W = NSRC >> s;
    localparam int H = W / 2;
    logic [W-1:0] w_in;
    logic [H-1:0] w_out;
    logic         lo_nz;
    if (s == 0) begin : g_first
      assign w_in = vec_i;
    end else begin : g_next
      assign w_in = g_stage[s-1].w_out;
    end
    assign lo_nz = |w_in[H-1:0];
    assign w_out = lo_nz ? w_in[H-1:0] : w_in[W-1:H];
    assign idx_o[LEVELS-1-s] = ~lo_nz;
  end

  // The surviving bit is set exactly when some input bit is set.
  assign valid_o = g_stage[LEVELS-1].w_out[0];

endmodule

// File: rtl/irq_merge.sv
module irq_merge
  import irq_merge_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_we,
  input  logic [NSRC-1:0] set_data,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_data,
  input  logic [NSRC-1:0] req,
  input  logic [1:0]      rd_sel,
  output logic [NSRC-1:0] rd_data,
  output logic [IDXW-1:0] win_idx,
  output logic            win_valid,
  output logic            cpu_irq
);

  logic [NSRC-1:0] mask;
  logic [NSRC-1:0] status;
  logic [NSRC-1:0] below_win;
  logic            any_pend;
  logic            irq_q;

  irq_mask_reg #(.NSRC(NSRC)) i_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_we   (set_we),
    .set_data (set_data),
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .mask_o   (mask)
  );

  assign status   = req & mask;
  assign any_pend = |status;

  irq_prio_find #(.NSRC(NSRC)) i_prio (
    .vec_i   (status),
    .idx_o   (win_idx),
    .valid_o (win_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_pend;
  end
  assign cpu_irq = irq_q;

  always_comb begin
    unique case (rsel_e'(rd_sel))
      RSEL_STATUS: rd_data = status;
      RSEL_MASK:   rd_data = mask;
      default:     rd_data = '0;
    endcase
  end

  // Bits strictly below the reported winner, for the priority check.
  assign below_win = (NSRC'(1) << win_idx) - NSRC'(1);

  // R6: the reported winner is pending-and-enabled
  assert_winner_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> status[win_idx]);

  // R6: nothing lower-numbered is pending-and-enabled
  assert_winner_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> ((status & below_win) == '0));

  // R7: the valid flag tracks a nonzero status
  assert_valid_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid == any_pend);

  // R8: the CPU line follows the status one cycle later
  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |=> cpu_irq);
  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |=> !cpu_irq);

  // R4: mask is empty on the first cycle out of reset
  assert_reset_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask == '0));

endmodule

// File: tb/test_irq_merge.sv
module test_irq_merge;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 32;
  localparam int IDXW = 5;
  localparam int NVEC = 8;

  localparam logic [31:0] T_SET [0:NVEC-1] = '{
    32'h0000_00F0, 32'h8000_0000, 32'h0000_0000, 32'h0000_0001,
    32'h0001_0100, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF};
  localparam logic [31:0] T_CLR [0:NVEC-1] = '{
    32'h0000_0000, 32'h0000_0010, 32'h0000_00E0, 32'h0000_0001,
    32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000};
  localparam logic [31:0] T_REQ [0:NVEC-1] = '{
    32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
    32'h0000_0000, 32'h0001_0000, 32'hFFFF_FFFF, 32'h0000_0002};
  localparam logic [31:0] T_MASK [0:NVEC-1] = '{
    32'h0000_00F0, 32'h8000_00E0, 32'h8000_0000, 32'h8000_0000,
    32'h8001_0100, 32'h8001_0100, 32'h0000_0000, 32'hFFFF_FFFF};
  localparam logic [31:0] T_STAT [0:NVEC-1] = '{
    32'h0000_00F0, 32'h8000_00E0, 32'h8000_0000, 32'h8000_0000,
    32'h0000_0000, 32'h0001_0000, 32'h0000_0000, 32'h0000_0002};
  localparam logic [4:0] T_IDX [0:NVEC-1] = '{
    5'd4, 5'd5, 5'd31, 5'd31, 5'd0, 5'd16, 5'd0, 5'd1};
  localparam logic T_VLD [0:NVEC-1] = '{1, 1, 1, 1, 0, 1, 0, 1};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            set_we = 1'b0;
  logic [NSRC-1:0] set_data = '0;
  logic            clr_we = 1'b0;
  logic [NSRC-1:0] clr_data = '0;
  logic [NSRC-1:0] req = '0;
  logic [1:0]      rd_sel = 2'd0;
  logic [NSRC-1:0] rd_data;
  logic [IDXW-1:0] win_idx;
  logic            win_valid;
  logic            cpu_irq;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_merge #(.NSRC(NSRC)) i_irq_merge (
    .clk(clk), .rst_n(rst_n),
    .set_we(set_we), .set_data(set_data),
    .clr_we(clr_we), .clr_data(clr_data),
    .req(req), .rd_sel(rd_sel), .rd_data(rd_data),
    .win_idx(win_idx), .win_valid(win_valid), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] val);
    rd_sel = sel;
    #1;
    val = rd_data;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    // R4: reset state
    repeat (2) @(negedge clk);
    rd(2'd3, v); chk("R4 mask in reset", v, 32'h0);
    chk("R4 irq in reset", {31'b0, cpu_irq}, 32'h0);
    rst_n = 1'b1;
    req = '1;
    @(negedge clk);
    rd(2'd3, v); chk("R4 mask after reset", v, 32'h0);
    rd(2'd2, v); chk("R4 status after reset", v, 32'h0);
    @(negedge clk);
    chk("R4 irq after reset", {31'b0, cpu_irq}, 32'h0);

    // Table walk: R1 R2 R3 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      set_we = 1'b1; set_data = T_SET[i];
      clr_we = 1'b1; clr_data = T_CLR[i];
      req = T_REQ[i];
      @(negedge clk);
      set_we = 1'b0; clr_we = 1'b0;
      rd(2'd3, v); chk("R1 R2 R3 mask", v, T_MASK[i]);
      rd(2'd2, v); chk("R5 status", v, T_STAT[i]);
      chk("R7 valid", {31'b0, win_valid}, {31'b0, T_VLD[i]});
      if (T_VLD[i]) chk("R6 index", {27'b0, win_idx}, {27'b0, T_IDX[i]});
      @(negedge clk);
      chk("R8 irq", {31'b0, cpu_irq}, {31'b0, T_VLD[i]});
    end

    // R9: write-only ports read zero while mask is all ones
    rd(2'd0, v); chk("R9 set port reads 0", v, 32'h0);
    rd(2'd1, v); chk("R9 clr port reads 0", v, 32'h0);
    rd(2'd3, v); chk("R9 mask readback", v, 32'hFFFF_FFFF);

    // R8: one-cycle latency on a rising request
    req = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 irq low with no request", {31'b0, cpu_irq}, 32'h0);
    req = 32'h0000_0001;
    #1;
    chk("R6 index zero wins", {27'b0, win_idx}, 32'h0);
    chk("R8 irq not yet raised", {31'b0, cpu_irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq raised next cycle", {31'b0, cpu_irq}, 32'h1);

    // R3: collision on a single bit, other bits untouched
    set_we = 1'b1; set_data = 32'h0000_0001;
    clr_we = 1'b1; clr_data = 32'h0000_0001;
    @(negedge clk);
    set_we = 1'b0; clr_we = 1'b0;
    rd(2'd3, v); chk("R3 clear wins on shared bit", v, 32'hFFFF_FFFE);
    chk("R7 valid low after collision", {31'b0, win_valid}, 32'h0);

    // R4: reset during operation empties the mask
    rst_n = 1'b0;
    #1;
    rd(2'd3, v); chk("R4 mid-run reset mask", v, 32'h0);
    chk("R4 mid-run reset irq", {31'b0, cpu_irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule